// File: doc/BRIEF.md
# DS3 Frame Synchronizer

This block sits behind the line decoder of a DS3 receiver. It takes the decoded serial bit stream, hunts for the overhead framing bits of the 4760-bit M-frame and reports lock on a plain out-of-frame status pin. Each accepted bit is passed through one cycle later with two strobes: one marks the first bit of the M-frame, the other marks payload bits. The strobes are derived from a free-running frame position counter, so they never stop. Out of reset they count from the first accepted bit. During a search they keep the last known alignment. When lock is declared they jump to the alignment that was found. If a later lock lands on a different bit position than the one held before, a sticky change-of-alignment flag is raised, and a write-one-to-clear input clears it.

The frame is parameterised by the payload length of a block (84 in the standard format). A subframe is 8 blocks of one overhead bit plus the payload. A frame is 7 subframes. Lock requires a set number of error-free subframes of framing bits and the multiframe marker pattern. Loss of lock is declared from a sliding window of framing-bit errors.

The input stream is valid/ready. The block never applies back-pressure: `in_ready` is held high, and every bit presented with `in_valid` is consumed in that cycle. The output stream has a valid but no ready. The consumer must take each output bit in the cycle it is offered.

Top module: `ds3_frame_sync`

## Requirements
- R1: `in_ready` is always 1. A bit accepted with `in_valid` appears on `out_data` with `out_valid` high exactly one cycle later. `out_valid` is low one cycle after a cycle without `in_valid`.
- R2: Bit positions in a frame are numbered from 0, with block length B = PAY_BITS+1. `out_den` is 0 on positions that are multiples of B (overhead) and 1 elsewhere. `out_sof` is 1 only on position 0 of the 7×8×B-bit frame.
- R3: After reset, `oof` is 1 and `cofa` is 0. The first accepted bit is given frame position 0, and the strobes count on from there.
- R4: Locking rules:
  - Number the blocks of a subframe 0..7 and the subframes of a frame 0..6.
  - The overhead bits of blocks 1, 3, 5 and 7 must read 1, 0, 0, 1.
  - The block-0 overhead bits of subframes 4, 5 and 6 must read 0, 1, 0.
  - `oof` falls after CONFIRM consecutive subframes with correct framing bits, the last of which is subframe 6 with that marker pattern.
  - From the beat that ends that subframe onward, the strobes follow the found alignment.
- R5: While in frame, `oof` rises on the beat whose framing bit makes 3 of the last 8 framing bits wrong. Two wrong bits in any 8 leave `oof` low.
- R6: While `oof` is 1, the strobes continue with the period and phase they had before the search began.
- R7: `cofa` rises when lock is declared at a position other than the one the freewheeling strobes held. It does not rise on the first lock after reset, and it does not rise on a relock at the same position.
- R8: `cofa` stays set until a cycle with `cofa_clr` at 1 clears it. A new alignment change in the same cycle as a clear leaves it set.
- R9: Cycles without `in_valid` do not advance the frame position, so alignment survives gaps in the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit is valid |
| in_data | input | 1 | Decoded serial input bit |
| cofa_clr | input | 1 | Write-one-to-clear for `cofa` |
| in_ready | output | 1 | Always high; the block never stalls |
| out_valid | output | 1 | Output bit is valid |
| out_data | output | 1 | Delayed copy of the input bit |
| out_sof | output | 1 | Output bit is the first bit of the M-frame |
| out_den | output | 1 | Output bit is a payload bit |
| oof | output | 1 | Out-of-frame status |
| cofa | output | 1 | Sticky change-of-frame-alignment flag |

## Verification
The bench feeds framed streams that start at offsets spread across the whole frame, with idle cycles scattered among the bits. It checks every strobe against a bit-position count kept in the bench, both before and after lock. A design that hunted with the wrong slip rule, or that started the frame one bit off at lock, would misplace `out_sof` on every following frame. A counter that advanced on idle cycles would drift. The error window is probed with two and then three wrong framing bits: an off-by-one threshold either drops lock too early or never drops it. The bench also checks that freewheeling keeps the old phase through a search, and it relocks at the same position and at two shifted positions. This catches a flag that fires on every relock, misses a real shift, or loses a clear/set race.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  // Fixed by the DS3 M-frame layout; behaviour decodes these positions.
  localparam int NUM_BLK = 8;
  localparam int NUM_SUB = 7;
  localparam logic [2:0] M_MARK = 3'b010;  // block-0 bits of subframes 4,5,6

  // Expected overhead value at an odd block index (blocks 1,3,5,7 -> 1,0,0,1)
  function automatic logic f_expect(input logic [2:0] blk);
    return (blk == 3'd1) || (blk == 3'd7);
  endfunction
endpackage

// File: rtl/fsync_pos_cnt.sv
module fsync_pos_cnt #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SUBS     = 7,
  localparam int BW = $clog2(BLK_BITS),
  localparam int KW = $clog2(BLKS),
  localparam int SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  output logic [BW-1:0] bit_idx,
  output logic [KW-1:0] blk_idx,
  output logic [SW-1:0] sub_idx,
  output logic          sub_end,
  output logic          frm_end
);
  logic last_bit, last_blk, last_sub;

  assign last_bit = (bit_idx == BW'(BLK_BITS - 1));
  assign last_blk = (blk_idx == KW'(BLKS - 1));
  assign last_sub = (sub_idx == SW'(SUBS - 1));
  assign sub_end  = last_bit && last_blk;
  assign frm_end  = sub_end && last_sub;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      bit_idx <= '0;
      blk_idx <= '0;
      sub_idx <= '0;
    end else if (adv) begin
      if (!last_bit) begin
        bit_idx <= bit_idx + 1'b1;
      end else begin
        bit_idx <= '0;
        if (!last_blk) begin
          blk_idx <= blk_idx + 1'b1;
        end else begin
          blk_idx <= '0;
          sub_idx <= last_sub ? '0 : sub_idx + 1'b1;
        end
      end
    end
  end

  // R9: a position only moves on an accepted bit
  a_r9_hold_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable({bit_idx, blk_idx, sub_idx}))
    else $error("position moved without a beat");
endmodule

// File: rtl/fsync_hunt.sv
module fsync_hunt import fsync_pkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int CONFIRM  = 4,
  localparam int CW = $clog2(CONFIRM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic adv,
  input  logic bit_in,
  output logic lock
);
  localparam int BW = $clog2(BLK_BITS);

  logic [BW-1:0] h_bit;
  logic [2:0]    h_blk;
  logic [0:0]    h_sub;
  logic          h_sub_end, h_frm_end;
  logic          at_oh, f_pos, m_pos, slip;
  logic [CW-1:0] good_cnt;
  logic          sub_bad;
  logic [2:0]    m_hist;
  logic          hunt_unused;

  // Candidate position within one subframe; holding it for a beat slips by one bit
  fsync_pos_cnt #(.BLK_BITS(BLK_BITS), .BLKS(NUM_BLK), .SUBS(1)) u_cand (
    .clk(clk), .rst_n(rst_n), .adv(adv && en && !slip), .load(!en),
    .bit_idx(h_bit), .blk_idx(h_blk), .sub_idx(h_sub),
    .sub_end(h_sub_end), .frm_end(h_frm_end));

  assign hunt_unused = ^{h_sub, h_frm_end};
  assign at_oh = (h_bit == '0);
  assign f_pos = at_oh && h_blk[0];
  assign m_pos = at_oh && (h_blk == 3'd0);
  assign slip  = en && adv && f_pos && (bit_in != f_expect(h_blk));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      good_cnt <= '0;
      sub_bad  <= 1'b0;
      m_hist   <= 3'b111;
    end else if (adv) begin
      if (slip) begin
        sub_bad  <= 1'b1;
        good_cnt <= '0;
        m_hist   <= 3'b111;
      end else begin
        if (m_pos) m_hist <= {m_hist[1:0], bit_in};
        if (h_sub_end) begin
          sub_bad <= 1'b0;
          if (sub_bad)                      good_cnt <= '0;
          else if (good_cnt != CW'(CONFIRM)) good_cnt <= good_cnt + 1'b1;
        end
      end
    end
  end

  assign lock = en && adv && h_sub_end && !sub_bad &&
                (int'(good_cnt) >= CONFIRM - 1) && (m_hist == M_MARK);

  // R4: a slipped subframe can never be the one that declares lock
  a_r4_no_lock_after_slip: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !lock)
    else $error("lock right after a slip");
endmodule

// File: rtl/fsync_fmon.sv
module fsync_fmon #(
  parameter int WIN = 8,
  parameter int LIM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chk,
  input  logic err,
  input  logic lock,
  output logic oof
);
  localparam int NW = $clog2(WIN + 1);

  logic [WIN-1:0] win, win_nxt;
  logic [NW-1:0]  ones;

  always_comb begin
    win_nxt = {win[WIN-2:0], err};
    ones    = '0;
    for (int i = 0; i < WIN; i++) ones = ones + NW'(win_nxt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof <= 1'b1;
      win <= '0;
    end else if (oof) begin
      win <= '0;
      if (lock) oof <= 1'b0;
    end else if (chk) begin
      if (int'(ones) >= LIM) begin
        oof <= 1'b1;
        win <= '0;
      end else begin
        win <= win_nxt;
      end
    end
  end

  // R5: a beat without a wrong framing bit never drops lock
  a_r5_clean_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!oof && !(chk && err)) |=> !oof)
    else $error("lock lost without a framing error");
endmodule

// File: rtl/ds3_frame_sync.sv
module ds3_frame_sync import fsync_pkg::*; #(
  parameter int PAY_BITS = 84,
  parameter int CONFIRM  = 4,
  parameter int ERR_WIN  = 8,
  parameter int ERR_LIM  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_data,
  input  logic cofa_clr,
  output logic in_ready,
  output logic out_valid,
  output logic out_data,
  output logic out_sof,
  output logic out_den,
  output logic oof,
  output logic cofa
);
  localparam int BLK_BITS = PAY_BITS + 1;
  localparam int BW = $clog2(BLK_BITS);
  localparam int SW = $clog2(NUM_SUB);

  logic [BW-1:0] m_bit;
  logic [2:0]    m_blk;
  logic [SW-1:0] m_sub;
  logic          m_sub_end, m_frm_end;
  logic          m_oh, m_zero, m_fpos, m_err;
  logic          hunt_lock, had_lock;
  logic          top_unused;

  assign in_ready   = 1'b1;
  assign top_unused = m_sub_end;

  // Frame position that drives the strobes; reloaded only by a lock
  fsync_pos_cnt #(.BLK_BITS(BLK_BITS), .BLKS(NUM_BLK), .SUBS(NUM_SUB)) u_main (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .load(hunt_lock),
    .bit_idx(m_bit), .blk_idx(m_blk), .sub_idx(m_sub),
    .sub_end(m_sub_end), .frm_end(m_frm_end));

  assign m_oh   = (m_bit == '0);
  assign m_zero = m_oh && (m_blk == '0) && (m_sub == '0);
  assign m_fpos = m_oh && m_blk[0];
  assign m_err  = (in_data != f_expect(m_blk));

  fsync_hunt #(.BLK_BITS(BLK_BITS), .CONFIRM(CONFIRM)) u_hunt (
    .clk(clk), .rst_n(rst_n), .en(oof), .adv(in_valid),
    .bit_in(in_data), .lock(hunt_lock));

  fsync_fmon #(.WIN(ERR_WIN), .LIM(ERR_LIM)) u_fmon (
    .clk(clk), .rst_n(rst_n), .chk(in_valid && m_fpos), .err(m_err),
    .lock(hunt_lock), .oof(oof));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 1'b0;
      out_sof   <= 1'b0;
      out_den   <= 1'b0;
      had_lock  <= 1'b0;
      cofa      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
      // the lock beat is the last payload bit of the newly found frame
      out_sof <= in_valid && !hunt_lock && m_zero;
      out_den <= in_valid && (hunt_lock || !m_oh);
      if (hunt_lock) had_lock <= 1'b1;
      if (hunt_lock && had_lock && !m_frm_end) cofa <= 1'b1;
      else if (cofa_clr)                       cofa <= 1'b0;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("accepted bit not forwarded");

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid)
    else $error("output valid without input");

  a_r2_sof_on_overhead: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !out_den)
    else $error("frame start marked as payload");

  a_r4_lock_sets_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof) |-> m_zero)
    else $error("lock did not restart the frame position");

  a_r7_cofa_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cofa) |-> $past(hunt_lock))
    else $error("alignment flag set without a lock");

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (cofa_clr && !hunt_lock) |=> !cofa)
    else $error("alignment flag not cleared");
endmodule

// File: tb/ds3_frame_sync_tb_top.sv
module ds3_frame_sync_tb_top;
  localparam int PAY = 4;
  localparam int BLK = PAY + 1;
  localparam int SUBL = BLK * 8;
  localparam int FRM = SUBL * 7;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_data, cofa_clr;
  logic in_ready, out_valid, out_data, out_sof, out_den, oof, cofa;

  always #2 clk = ~clk;  // 250 MHz

  ds3_frame_sync #(.PAY_BITS(PAY), .CONFIRM(4), .ERR_WIN(8), .ERR_LIM(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cofa_clr(cofa_clr), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_den(out_den),
    .oof(oof), .cofa(cofa));

  int checks = 0, fails = 0;
  int dpos, sphase, mm, lockseen, oofseen;
  logic prev_oof, gap_en, done = 1'b0;
  logic [15:0] lf;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic gen_bit(input int p, input logic rnd);
    int bp, bk, sb;
    bp = p % BLK; bk = (p / BLK) % 8; sb = p / SUBL;
    if (bp != 0) return rnd;
    if (bk == 0) return (sb <= 1) || (sb == 5);   // X=1, P=0, marker 0,1,0
    if (bk == 1 || bk == 7) return 1'b1;
    return 1'b0;                                 // F2,F3 and all C bits
  endfunction

  function automatic logic is_f(input int p);
    return (p % BLK == 0) && (((p / BLK) % 8) % 2 == 1);
  endfunction

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic beat(input logic v, input logic d);
    in_valid = v; in_data = d;
    @(posedge clk); #1;
  endtask

  // Sends one stream bit and checks data and strobes against the bench position
  task automatic tx(input logic flip);
    logic b, lb;
    int p, ep;
    step_lf();
    if (gap_en && lf[3:0] == 4'd0) begin
      beat(1'b0, 1'b0);
      if (out_valid !== 1'b0) mm++;
    end
    step_lf();
    b = gen_bit(sphase, lf[0]) ^ flip;
    p = sphase;
    beat(1'b1, b);
    sphase = (sphase + 1) % FRM;
    if (out_valid !== 1'b1 || out_data !== b) mm++;
    lb = prev_oof && !oof;
    ep = lb ? p : dpos;
    if (out_sof !== (ep == 0) || out_den !== (ep % BLK != 0)) mm++;
    dpos = (ep + 1) % FRM;
    prev_oof = oof;
    if (lb) lockseen = 1;
    if (oof) oofseen = 1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = 1'b0; cofa_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    dpos = 0; prev_oof = 1'b1; lockseen = 0; mm = 0;
  endtask

  task automatic wait_lock(input int lim);
    int n = 0;
    lockseen = 0;
    while (!lockseen && n < lim) begin tx(1'b0); n++; end
  endtask

  task automatic send_err();
    while (!is_f(sphase)) tx(1'b0);
    tx(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state (R1, R3)
    do_reset();
    check(oof === 1'b1, "R3 oof after reset", oof, 1);
    check(cofa === 1'b0, "R3 cofa after reset", cofa, 0);
    check(out_valid === 1'b0, "R1 no output after reset", out_valid, 0);
    check(in_ready === 1'b1, "R1 ready", in_ready, 1);
    gap_en = 1'b0; sphase = 100; lf = 16'h1234;
    tx(1'b0);
    check(out_sof === 1'b1 && out_den === 1'b0, "R3 first beat is frame origin", out_sof, 1);
    tx(1'b0);
    check(mm == 0 && out_den === 1'b1, "R3 strobes count from reset", mm, 0);

    // Sweep of start offsets with idle gaps (R2, R4, R7, R9)
    for (int off = 0; off < FRM; off += 7) begin
      do_reset();
      sphase = off; lf = 16'hACE1 ^ 16'(off); gap_en = 1'b1; oofseen = 0;
      wait_lock(4000);
      check(lockseen == 1, "R4 lock reached", lockseen, 1);
      check(cofa === 1'b0, "R7 no flag on first lock", cofa, 0);
      oofseen = 0;
      for (int i = 0; i < 2 * FRM; i++) tx(1'b0);
      check(mm == 0, "R2 R9 strobe alignment incl. gaps", mm, 0);
      check(oofseen == 0, "R5 clean stream keeps lock", oofseen, 0);
    end

    // Directed error, freewheel and realignment cases
    do_reset();
    sphase = 0; lf = 16'h5A5A; gap_en = 1'b0;
    wait_lock(4000);
    check(lockseen == 1, "R4 directed lock", lockseen, 1);

    oofseen = 0;
    send_err();
    tx(1'b0);
    while (!is_f(sphase)) tx(1'b0);
    tx(1'b0);
    send_err();
    for (int i = 0; i < 200; i++) tx(1'b0);
    check(oofseen == 0, "R5 two errors in eight keep lock", oofseen, 0);

    send_err();
    send_err();
    check(oof === 1'b0, "R5 still locked after two", oof, 0);
    send_err();
    check(oof === 1'b1, "R5 third error drops lock", oof, 1);

    wait_lock(4000);
    check(mm == 0, "R6 freewheel keeps old phase", mm, 0);
    check(cofa === 1'b0, "R7 same-position relock", cofa, 0);

    sphase = (sphase + 3) % FRM;
    wait_lock(6000);
    check(lockseen == 1 && mm == 0, "R6 R4 shifted relock alignment", mm, 0);
    check(cofa === 1'b1, "R7 flag on new position", cofa, 1);
    for (int i = 0; i < 50; i++) tx(1'b0);
    check(cofa === 1'b1, "R8 flag is sticky", cofa, 1);
    cofa_clr = 1'b1; tx(1'b0); cofa_clr = 1'b0;
    check(cofa === 1'b0, "R8 clear", cofa, 0);

    sphase = (sphase + 11) % FRM;
    cofa_clr = 1'b1;
    wait_lock(6000);
    check(cofa === 1'b1, "R8 set wins over clear", cofa, 1);
    cofa_clr = 1'b0; tx(1'b0);
    check(cofa === 1'b1, "R8 held after clear released", cofa, 1);
    cofa_clr = 1'b1; tx(1'b0); cofa_clr = 1'b0;
    check(cofa === 1'b0, "R8 second clear", cofa, 0);
    check(mm == 0, "R2 R6 alignment through directed run", mm, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule